// File: doc/BRIEF.md
# Multi-Port MDIO Management Target

This block is the serial management endpoint of an eight-port transceiver. A single pair of management pins (clock `mdc`, data `mdio`) reaches all eight logical PHYs. Each port answers at its own PHY address, the strap base plus the port index. A frame that addresses one of the eight is decoded and turned into a read or write of that port's bank of 32 sixteen-bit registers. Frames for any other address are ignored.

The pins are oversampled with the system clock `clk`. Bits are taken on rising edges of `mdc`. Read data is launched just after a rising edge, so the controller captures it on the following rising edge. The data pin is split into an input, an output value and an output enable, which the pad ring combines into a tri-state buffer. The `md_off` input silences the target completely. The `reduced_map` input selects a narrow address map in which only the two upper strap bits count.

Top module: `mdio_octal_target`

## Requirements
- R1: After reset, `mdio_oe` is low and every register of every port reads back as 0x0000.
- R2: A frame is recognised only after at least 32 consecutive ones on `mdio_i`. A frame preceded by only 31 ones causes no drive and no register change.
- R3: The start field must be 0 then 1. Any other start pattern aborts the frame without drive or register change.
- R4: The opcode bits are taken in order first, second. The pair 1,0 is a read and 0,1 is a write. The pairs 0,0 and 1,1 abort the frame without drive or register change.
- R5: In normal mapping, port p (0 to 7) answers PHY address strap+p, sent MSB first. An address outside that window gives no drive and no write. Window addresses above 31 do not exist and never wrap.
- R6: With `reduced_map` high, the window base is `{strap_addr[4:3],3'b000}`, so it is 0, 8, 16 or 24. `strap_addr[2:0]` is ignored.
- R7: On a read, `mdio_oe` stays low for turnaround bit 1. The target drives 0 for turnaround bit 2, then register bits 15 down to 0. Each value is launched after the preceding rising edge of `mdc`. The target releases the line after the last data bit.
- R8: On a write, `mdio_oe` never rises. The 16 data bits, MSB first, are written to the addressed port's register only after the last data bit.
- R9: While `md_off` is high, `mdio_oe` is low and no frame writes any register.
- R10: Each port's registers are separate. A write to one port leaves the same register index in every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management pins |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Management data seen at the pad |
| mdio_o | output | 1 | Data value driven when `mdio_oe` is high |
| mdio_oe | output | 1 | Pad output enable; low means high impedance |
| md_off | input | 1 | High disables the interface completely |
| strap_addr | input | 5 | Strapped base PHY address |
| reduced_map | input | 1 | High selects the four-base address map |

## Verification
The bench targets the window edges: the first and last port addresses, the address one below the base, the address one past the top, which a wrapping port index would alias onto port 0, and a base near 31. A short preamble of 31 ones, bad start patterns and the two invalid opcodes must all leave the registers untouched. A parser that counted badly or skipped a field check would write a register that later reads back non-zero. Every read checks the enable bit by bit. An off-by-one launch shows up as a shifted data word or a driven first turnaround bit. Reduced mapping is checked with low strap bits that would move the window if they were not masked. Writes to neighbouring ports expose a shared bank.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

    localparam int ADDR_W = 5;

    typedef logic [ADDR_W-1:0] mdio_addr_t;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_START,
        PH_OP,
        PH_PHY,
        PH_REG,
        PH_TA,
        PH_DATA
    } phase_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef struct packed {
        logic       is_read;
        mdio_addr_t phy;
        mdio_addr_t regad;
    } frame_hdr_t;

    // Base of the answering window; in the reduced map the low bits drop out.
    function automatic mdio_addr_t window_base(mdio_addr_t strap, logic reduced,
                                               int low_bits);
        mdio_addr_t low_mask;
        low_mask = mdio_addr_t'((1 << low_bits) - 1);
        return reduced ? (strap & ~low_mask) : strap;
    endfunction

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc,
    input  logic mdio_i,
    output logic rise,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_sh;
    logic [STAGES-1:0] dat_sh;
    logic              mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sh   <= '0;
            dat_sh   <= '0;
            mdc_prev <= 1'b0;
        end else begin
            mdc_sh   <= {mdc_sh[STAGES-2:0], mdc};
            dat_sh   <= {dat_sh[STAGES-2:0], mdio_i};
            mdc_prev <= mdc_sh[STAGES-1];
        end
    end

    assign rise    = mdc_sh[STAGES-1] & ~mdc_prev;
    assign bit_val = dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
#(
    parameter int NPORT   = 8,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32,
    parameter int PW      = 3,
    parameter int RW      = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          md_off,
    input  logic          rise,
    input  logic          bit_val,
    input  mdio_addr_t    base,
    input  logic [DW-1:0] rd_data,
    output logic [PW-1:0] port_idx,
    output logic [RW-1:0] reg_idx,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);
    localparam int CW = $clog2((PRE_LEN > DW ? PRE_LEN : DW) + 1);

    phase_t          phase;
    logic [CW-1:0]   cnt;
    frame_hdr_t      hdr;
    logic            op_first;
    logic [DW-1:0]   rx_sh;
    logic [DW-1:0]   tx_sh;
    mdio_addr_t      offset;
    logic            in_window;

    assign offset    = hdr.phy - base;
    assign in_window = (hdr.phy >= base) && (offset < mdio_addr_t'(NPORT));
    assign port_idx  = offset[PW-1:0];
    assign reg_idx   = hdr.regad[RW-1:0];

    always_ff @(posedge clk) begin
        if (rst || md_off) begin
            phase    <= PH_HUNT;
            cnt      <= '0;
            hdr      <= '0;
            op_first <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (rise) begin
                unique case (phase)
                    PH_HUNT: begin
                        if (bit_val) begin
                            if (cnt != CW'(PRE_LEN)) cnt <= cnt + 1'b1;
                        end else if (cnt == CW'(PRE_LEN)) begin
                            phase <= PH_START;
                            cnt   <= '0;
                        end else begin
                            cnt <= '0;
                        end
                    end
                    PH_START: begin
                        phase <= bit_val ? PH_OP : PH_HUNT;
                        cnt   <= '0;
                    end
                    PH_OP: begin
                        if (cnt == '0) begin
                            op_first <= bit_val;
                            cnt      <= cnt + 1'b1;
                        end else begin
                            cnt <= '0;
                            if ({op_first, bit_val} == OPC_READ) begin
                                hdr.is_read <= 1'b1;
                                phase       <= PH_PHY;
                            end else if ({op_first, bit_val} == OPC_WRITE) begin
                                hdr.is_read <= 1'b0;
                                phase       <= PH_PHY;
                            end else begin
                                phase <= PH_HUNT;
                            end
                        end
                    end
                    PH_PHY: begin
                        hdr.phy <= {hdr.phy[ADDR_W-2:0], bit_val};
                        if (cnt == CW'(ADDR_W-1)) begin
                            phase <= PH_REG;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_REG: begin
                        hdr.regad <= {hdr.regad[ADDR_W-2:0], bit_val};
                        if (cnt == CW'(ADDR_W-1)) begin
                            phase <= in_window ? PH_TA : PH_HUNT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_TA: begin
                        if (cnt == '0) begin
                            // first turnaround bit sampled: claim the line with a zero
                            if (hdr.is_read) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end
                            cnt <= cnt + 1'b1;
                        end else begin
                            if (hdr.is_read) begin
                                mdio_o <= rd_data[DW-1];
                                tx_sh  <= {rd_data[DW-2:0], 1'b0};
                            end
                            phase <= PH_DATA;
                            cnt   <= '0;
                        end
                    end
                    PH_DATA: begin
                        rx_sh <= {rx_sh[DW-2:0], bit_val};
                        if (hdr.is_read) begin
                            mdio_o <= tx_sh[DW-1];
                            tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                        end
                        if (cnt == CW'(DW-1)) begin
                            mdio_oe <= 1'b0;
                            if (!hdr.is_read) begin
                                wr_en   <= 1'b1;
                                wr_data <= {rx_sh[DW-2:0], bit_val};
                            end
                            phase <= PH_HUNT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        phase <= PH_HUNT;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
    parameter int NPORT = 8,
    parameter int NREG  = 32,
    parameter int DW    = 16,
    parameter int PW    = 3,
    parameter int RW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] port,
    input  logic [RW-1:0] regi,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] port_rd [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [DW-1:0] regs [NREG];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (we && port == PW'(p)) begin
                regs[regi] <= wdata;
            end
        end

        assign port_rd[p] = regs[regi];
    end

    assign rdata = port_rd[port];
endmodule

// File: rtl/mdio_octal_target.sv
module mdio_octal_target
    import mdio_tgt_pkg::*;
#(
    parameter int NPORT       = 8,
    parameter int NREG        = 32,
    parameter int DW          = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mdc,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       md_off,
    input  logic [4:0] strap_addr,
    input  logic       reduced_map
);
    localparam int PW = $clog2(NPORT);
    localparam int RW = $clog2(NREG);

    logic          smp_rise;
    logic          smp_bit;
    mdio_addr_t    base;
    logic [PW-1:0] bank_port;
    logic [RW-1:0] bank_reg;
    logic          bank_we;
    logic [DW-1:0] bank_wdata;
    logic [DW-1:0] bank_rdata;

    assign base = window_base(strap_addr, reduced_map, PW);

    mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .rise    (smp_rise),
        .bit_val (smp_bit)
    );

    mdio_frame_fsm #(
        .NPORT(NPORT), .DW(DW), .PRE_LEN(PRE_LEN), .PW(PW), .RW(RW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .md_off   (md_off),
        .rise     (smp_rise),
        .bit_val  (smp_bit),
        .base     (base),
        .rd_data  (bank_rdata),
        .port_idx (bank_port),
        .reg_idx  (bank_reg),
        .wr_en    (bank_we),
        .wr_data  (bank_wdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank #(
        .NPORT(NPORT), .NREG(NREG), .DW(DW), .PW(PW), .RW(RW)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .port  (bank_port),
        .regi  (bank_reg),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );
endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk (
    input logic clk,
    input logic rst,
    input logic md_off,
    input logic mdio_o,
    input logic mdio_oe,
    input logic rise,
    input logic wr_en
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !mdio_oe)
        else $error("R1: output enabled right after reset");

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(md_off) |-> !mdio_oe)
        else $error("R9: line driven while disabled");

    a_r9_no_commit: assert property (@(posedge clk) disable iff (rst)
        $past(md_off) |-> !wr_en)
        else $error("R9: register write while disabled");

    a_r7_ta_low: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o)
        else $error("R7: first driven turnaround bit is not zero");

    a_r7_oe_on_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rise) && !$past(md_off)) |-> $stable(mdio_oe))
        else $error("R7: enable moved without an mdc rising edge");

    a_r8_write_silent: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !mdio_oe)
        else $error("R8: line driven while committing a write");
endmodule

bind mdio_octal_target mdio_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .md_off  (md_off),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rise    (smp_rise),
    .wr_en   (bank_we)
);

// File: tb/sim_mdio_octal_target.sv
module sim_mdio_octal_target;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mdc = 1'b0;
    logic       mdio_i = 1'b1;
    logic       mdio_o;
    logic       mdio_oe;
    logic       md_off = 1'b0;
    logic [4:0] strap_addr = 5'd4;
    logic       reduced_map = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       rq;
        bit          drive;
        logic [15:0] data;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] model [8][32];
    logic [32:0] cap_oe;
    logic [32:0] cap_o;
    logic        pre_bad;
    event        frame_done;

    always #5 clk = ~clk;

    mdio_octal_target u0 (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .md_off(md_off), .strap_addr(strap_addr),
        .reduced_map(reduced_map)
    );

    function automatic int bbase();
        return reduced_map ? int'({strap_addr[4:3], 3'b000}) : int'(strap_addr);
    endfunction

    function automatic bit inwin(logic [4:0] phy);
        return (int'(phy) >= bbase()) && (int'(phy) - bbase() < 8);
    endfunction

    // one mdc period; returns the line state the controller sees at the rising edge
    task automatic slot(input logic v, output logic s_oe, output logic s_o);
        mdio_i = v;
        mdc    = 1'b0;
        repeat (6) @(negedge clk);
        s_oe = mdio_oe;
        s_o  = mdio_o;
        mdc  = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input string rq, input int pre, input logic [1:0] st,
                         input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd);
        exp_t  it;
        bit    ok;
        logic  so, sd, v;
        ok = (pre >= 32) && (st == 2'b01) && (op == 2'b10 || op == 2'b01)
             && !md_off && inwin(phy);
        it.rq    = rq;
        it.drive = ok && (op == 2'b10);
        it.data  = ok ? model[int'(phy) - bbase()][ra] : 16'h0;
        if (ok && op == 2'b01) model[int'(phy) - bbase()][ra] = wd;
        exp_q.push_back(it);
        pre_bad = 1'b0;
        for (int k = 0; k < 2 + pre; k++) begin
            slot((k < 2) ? 1'b0 : 1'b1, so, sd);
            if (so) pre_bad = 1'b1;
        end
        for (int k = 0; k < 33; k++) begin
            if (k < 2)       v = st[1-k];
            else if (k < 4)  v = op[3-k];
            else if (k < 9)  v = phy[8-k];
            else if (k < 14) v = ra[13-k];
            else if (k < 16) v = (op == 2'b01) ? (k == 14) : 1'b1;
            else if (k < 32) v = (op == 2'b01) ? wd[31-k] : 1'b1;
            else             v = 1'b1;
            slot(v, so, sd);
            cap_oe[k] = so;
            cap_o[k]  = sd;
        end
        ->frame_done;
        @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        exp_t        it;
        logic [32:0] e_oe;
        logic [32:0] e_o;
        forever begin
            @(frame_done);
            it   = exp_q.pop_front();
            e_oe = '0;
            e_o  = '0;
            if (it.drive) begin
                for (int k = 15; k < 32; k++) e_oe[k] = 1'b1;
                for (int i = 0; i < 16; i++) e_o[16+i] = it.data[15-i];
            end
            checks++;
            if (pre_bad || cap_oe !== e_oe || (cap_o & e_oe) !== e_o) begin
                errors++;
                $display("FAIL %s oe=%h o=%h pre_drive=%b expected oe=%h o=%h",
                         it.rq, cap_oe, cap_o & e_oe, pre_bad, e_oe, e_o);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 8; p++)
            for (int r = 0; r < 32; r++) model[p][r] = 16'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (mdio_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1 mdio_oe=%b expected 0", mdio_oe);
        end
        // normal map, window 4..11
        frame("R1 reset read", 32, 2'b01, 2'b10, 5'd4, 5'd0, 16'h0);
        frame("R8 write", 32, 2'b01, 2'b01, 5'd6, 5'd3, 16'hA5C3);
        frame("R7 read back", 32, 2'b01, 2'b10, 5'd6, 5'd3, 16'h0);
        frame("R10 neighbour write", 32, 2'b01, 2'b01, 5'd7, 5'd3, 16'h1234);
        frame("R10 port6 intact", 32, 2'b01, 2'b10, 5'd6, 5'd3, 16'h0);
        frame("R10 port7", 32, 2'b01, 2'b10, 5'd7, 5'd3, 16'h0);
        frame("R5 top write", 32, 2'b01, 2'b01, 5'd11, 5'd31, 16'hFFFF);
        frame("R5 top read", 32, 2'b01, 2'b10, 5'd11, 5'd31, 16'h0);
        frame("R5 past top write", 32, 2'b01, 2'b01, 5'd12, 5'd31, 16'hBEEF);
        frame("R5 port0 unaliased", 32, 2'b01, 2'b10, 5'd4, 5'd31, 16'h0);
        frame("R5 below base", 32, 2'b01, 2'b10, 5'd3, 5'd0, 16'h0);
        // framing errors
        frame("R2 short preamble write", 31, 2'b01, 2'b01, 5'd5, 5'd1, 16'h1111);
        frame("R2 short preamble read", 31, 2'b01, 2'b10, 5'd5, 5'd1, 16'h0);
        frame("R2 register untouched", 32, 2'b01, 2'b10, 5'd5, 5'd1, 16'h0);
        frame("R3 start 00", 32, 2'b00, 2'b01, 5'd5, 5'd2, 16'h2222);
        frame("R3 start 11", 32, 2'b11, 2'b01, 5'd5, 5'd2, 16'h3333);
        frame("R3 register untouched", 32, 2'b01, 2'b10, 5'd5, 5'd2, 16'h0);
        frame("R4 opcode 00", 32, 2'b01, 2'b00, 5'd5, 5'd2, 16'h4444);
        frame("R4 opcode 11", 32, 2'b01, 2'b11, 5'd5, 5'd2, 16'h5555);
        frame("R4 register untouched", 32, 2'b01, 2'b10, 5'd5, 5'd2, 16'h0);
        // disable
        md_off = 1'b1;
        frame("R9 write while off", 32, 2'b01, 2'b01, 5'd5, 5'd4, 16'h7777);
        frame("R9 read while off", 32, 2'b01, 2'b10, 5'd5, 5'd4, 16'h0);
        md_off = 1'b0;
        frame("R9 register untouched", 32, 2'b01, 2'b10, 5'd5, 5'd4, 16'h0);
        // reduced map: strap 10111 -> base 16
        strap_addr  = 5'b10111;
        reduced_map = 1'b1;
        frame("R6 reduced write", 32, 2'b01, 2'b01, 5'd16, 5'd9, 16'h0F0F);
        frame("R6 reduced read", 32, 2'b01, 2'b10, 5'd16, 5'd9, 16'h0);
        frame("R6 reduced port7", 32, 2'b01, 2'b10, 5'd23, 5'd9, 16'h0);
        frame("R6 reduced miss", 32, 2'b01, 2'b10, 5'd24, 5'd9, 16'h0);
        reduced_map = 1'b0;
        frame("R6 normal map miss", 32, 2'b01, 2'b10, 5'd16, 5'd9, 16'h0);
        strap_addr  = 5'b11010;
        reduced_map = 1'b1;
        frame("R6 base 24 port7 write", 32, 2'b01, 2'b01, 5'd31, 5'd0, 16'hC0DE);
        frame("R6 base 24 port7 read", 32, 2'b01, 2'b10, 5'd31, 5'd0, 16'h0);
        reduced_map = 1'b0;
        strap_addr  = 5'd28;
        frame("R5 high base read", 32, 2'b01, 2'b10, 5'd31, 5'd0, 16'h0);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule